// File: doc/BRIEF.md
# AC-link output frame serializer

This block sits on the controller side of an AC'97 link and produces the outgoing serial stream together with the frame marker. It runs from the link bit clock and repeats a fixed 256-bit frame. Each frame opens with a 16-bit tag slot and then carries twelve 20-bit slots. All output bits are registered, so they change on the rising edge and the codec can sample them on the falling edge.

Three upstream sources feed the frame, and each uses a valid/ready handshake. The first is a codec register command: a read flag, a 7-bit register address and 16-bit write data. The other two are the left and right playback samples, each 20 bits wide. The block samples all three sources at the same point in the frame, once per frame, in the last bit time before a new frame starts. A source that is valid at that moment is consumed and sent in the next frame, and its tag flags are raised. A source that is not valid leaves its slots at zero and its tag flags low. Every reserved field and every reserved slot is sent as zeros.

Top module: `acl_out_framer`

## Requirements
- R1: A frame lasts 256 bit clocks. `sync_o` is high for the first 16 bit times of every frame, which is the tag slot, and low for the other 240. Both outputs come from registers.
- R2: The three ready outputs pulse high together for exactly one cycle per frame. The pulse occurs in the last bit time before the next frame, which is the cycle in which bit 254 of the current frame is on the line. A source that is valid in that cycle is consumed and appears in the next frame. A source that is not valid is sent as absent in that frame.
- R3: Tag bits 14, 13, 12 and 11 are the valid flags for slots 1, 2, 3 and 4. Tag bit 15 is high exactly when any of these flags is high. Tag bits 10 to 0 are zero.
- R4: When a command is consumed, slot 1 holds the read flag in bit 19, where 1 means read and 0 means write. Bits 18 to 12 hold the address and bits 11 to 0 are zero, and tag bit 14 is set. When no command is consumed, slot 1 is all zero and tag bit 14 is clear.
- R5: For a consumed write, slot 2 holds the write data in bits 19 to 4 with bits 3 to 0 zero, and tag bit 13 is set. For a consumed read, slot 2 is all zero and tag bit 13 is clear, whatever the write data input holds.
- R6: Slot 3 carries the left sample and slot 4 the right sample. Each keeps the upper 18 bits of its sample and sends bits 1 and 0 as zero. Tag bits 12 and 11 show whether each sample was consumed, and a slot whose sample was not consumed is all zero.
- R7: Slots 5 to 12 (frame bits 96 to 255) are always zero.
- R8: The tag and every slot are sent MSB first. Frame bit 0 is tag bit 15, and bit 19 of slot n is frame bit 16 + 20*(n-1).
- R9: While reset is asserted, `sync_o`, `sdata_o` and all ready outputs are low. The first frame after reset carries an all-zero tag and zero slots.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Link bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Register command offered |
| cmd_ready | output | 1 | Command consumed at frame boundary |
| cmd_rd | input | 1 | 1 = register read, 0 = register write |
| cmd_addr | input | 7 | Codec register address |
| cmd_wdata | input | 16 | Write data (ignored for reads) |
| pcm_l_valid | input | 1 | Left playback sample offered |
| pcm_l_ready | output | 1 | Left sample consumed |
| pcm_l_data | input | 20 | Left playback sample |
| pcm_r_valid | input | 1 | Right playback sample offered |
| pcm_r_ready | output | 1 | Right sample consumed |
| pcm_r_data | input | 20 | Right playback sample |
| sync_o | output | 1 | Frame marker, high during the tag slot |
| sdata_o | output | 1 | Serial output frame data |

## Verification
The bit and slot position counters drive both the frame marker and the ready pulse. If either counter drifts, `sync_o` or the ready pulse lands at the wrong position in the first frame where the drift happens, and the effect lasts until reset. A fault in the shadow fields or the slot multiplexer shows up as a wrong tag flag, a wrong field bit or a nonzero padding bit. It appears in the frame that follows the handshake, at the exact bit position of the field involved. The bench rebuilds every expected frame from the handshakes it observed and compares each slot, the tag and the marker at the end of the frame.

// File: rtl/acl_pkg.sv
package acl_pkg;

    localparam int ACL_ADDR_W = 7;
    localparam int ACL_DATA_W = 16;
    localparam int ACL_SLOT_W = 20;
    localparam int ACL_TAG_W  = 16;
    localparam int ACL_NSLOTS = 12;
    localparam int ACL_KEEP_W = 18;

    // Fields captured at a frame boundary and held for the whole next frame.
    typedef struct packed {
        logic                  cmd_vld;
        logic                  cmd_rd;
        logic [ACL_ADDR_W-1:0] cmd_addr;
        logic [ACL_DATA_W-1:0] cmd_wdata;
        logic                  l_vld;
        logic [ACL_SLOT_W-1:0] l_data;
        logic                  r_vld;
        logic [ACL_SLOT_W-1:0] r_data;
    } shadow_t;

endpackage

// File: rtl/acl_frame_timer.sv
module acl_frame_timer #(
    parameter int TAG_W     = acl_pkg::ACL_TAG_W,
    parameter int SLOT_W    = acl_pkg::ACL_SLOT_W,
    parameter int NUM_SLOTS = acl_pkg::ACL_NSLOTS,
    localparam int SIDX_W   = $clog2(NUM_SLOTS + 1),
    localparam int BIT_W    = $clog2(SLOT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [SIDX_W-1:0] slot_idx,
    output logic [BIT_W-1:0]  bit_idx,
    output logic              frame_end
);

    localparam logic [SIDX_W-1:0] LAST_SLOT = SIDX_W'(NUM_SLOTS);
    localparam logic [BIT_W-1:0]  TAG_TOP   = BIT_W'(TAG_W - 1);
    localparam logic [BIT_W-1:0]  SLOT_TOP  = BIT_W'(SLOT_W - 1);

    typedef struct packed {
        logic [SIDX_W-1:0] slot;
        logic [BIT_W-1:0]  bitn;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.bitn == '0) begin
            if (tmr_q.slot == LAST_SLOT) begin
                tmr_d.slot = '0;
                tmr_d.bitn = TAG_TOP;
            end else begin
                tmr_d.slot = tmr_q.slot + 1'b1;
                tmr_d.bitn = SLOT_TOP;
            end
        end else begin
            tmr_d.bitn = tmr_q.bitn - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q.slot <= '0;
            tmr_q.bitn <= TAG_TOP;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign slot_idx  = tmr_q.slot;
    assign bit_idx   = tmr_q.bitn;
    assign frame_end = (tmr_q.slot == LAST_SLOT) && (tmr_q.bitn == '0);

endmodule

// File: rtl/acl_field_latch.sv
module acl_field_latch #(
    parameter int ADDR_W = acl_pkg::ACL_ADDR_W,
    parameter int DATA_W = acl_pkg::ACL_DATA_W,
    parameter int SLOT_W = acl_pkg::ACL_SLOT_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic                  cmd_valid,
    input  logic                  cmd_rd,
    input  logic [ADDR_W-1:0]     cmd_addr,
    input  logic [DATA_W-1:0]     cmd_wdata,
    input  logic                  l_valid,
    input  logic [SLOT_W-1:0]     l_data,
    input  logic                  r_valid,
    input  logic [SLOT_W-1:0]     r_data,
    output acl_pkg::shadow_t      shadow
);

    acl_pkg::shadow_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load) begin
            // Every field is refreshed each frame; absent sources go invalid.
            sh_d.cmd_vld   = cmd_valid;
            sh_d.cmd_rd    = cmd_valid & cmd_rd;
            sh_d.cmd_addr  = cmd_valid ? cmd_addr  : '0;
            sh_d.cmd_wdata = cmd_valid ? cmd_wdata : '0;
            sh_d.l_vld     = l_valid;
            sh_d.l_data    = l_valid ? l_data : '0;
            sh_d.r_vld     = r_valid;
            sh_d.r_data    = r_valid ? r_data : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign shadow = sh_q;

endmodule

// File: rtl/acl_slot_mux.sv
module acl_slot_mux #(
    parameter int TAG_W     = acl_pkg::ACL_TAG_W,
    parameter int SLOT_W    = acl_pkg::ACL_SLOT_W,
    parameter int NUM_SLOTS = acl_pkg::ACL_NSLOTS,
    parameter int ADDR_W    = acl_pkg::ACL_ADDR_W,
    parameter int DATA_W    = acl_pkg::ACL_DATA_W,
    parameter int KEEP_W    = acl_pkg::ACL_KEEP_W,
    localparam int SIDX_W   = $clog2(NUM_SLOTS + 1),
    localparam int BIT_W    = $clog2(SLOT_W),
    localparam int A_PAD    = SLOT_W - 1 - ADDR_W,
    localparam int D_PAD    = SLOT_W - DATA_W,
    localparam int P_PAD    = SLOT_W - KEEP_W
) (
    input  acl_pkg::shadow_t  shadow,
    input  logic [SIDX_W-1:0] slot_idx,
    input  logic [BIT_W-1:0]  bit_idx,
    output logic              bit_o
);

    logic [NUM_SLOTS:1]  flags;
    logic [TAG_W-1:0]    tag;
    logic [SLOT_W-1:0]   words [0:NUM_SLOTS];
    logic [SLOT_W-1:0]   cur_word;

    always_comb begin
        flags    = '0;
        flags[1] = shadow.cmd_vld;
        flags[2] = shadow.cmd_vld & ~shadow.cmd_rd;
        flags[3] = shadow.l_vld;
        flags[4] = shadow.r_vld;
    end

    always_comb begin
        tag            = '0;
        tag[TAG_W-1]   = |flags;
        for (int s = 1; s <= NUM_SLOTS; s++) begin
            tag[TAG_W-1-s] = flags[s];
        end
    end

    for (genvar s = 0; s <= NUM_SLOTS; s++) begin : g_slot
        if (s == 0) begin : g_tag
            assign words[s] = {{(SLOT_W-TAG_W){1'b0}}, tag};
        end else if (s == 1) begin : g_addr
            assign words[s] = flags[1]
                ? {shadow.cmd_rd, shadow.cmd_addr, {A_PAD{1'b0}}}
                : '0;
        end else if (s == 2) begin : g_wdata
            assign words[s] = flags[2]
                ? {shadow.cmd_wdata, {D_PAD{1'b0}}}
                : '0;
        end else if (s == 3) begin : g_left
            assign words[s] = flags[3]
                ? {shadow.l_data[SLOT_W-1 -: KEEP_W], {P_PAD{1'b0}}}
                : '0;
        end else if (s == 4) begin : g_right
            assign words[s] = flags[4]
                ? {shadow.r_data[SLOT_W-1 -: KEEP_W], {P_PAD{1'b0}}}
                : '0;
        end else begin : g_rsvd
            assign words[s] = '0;
        end
    end

    always_comb begin
        cur_word = '0;
        for (int s = 0; s <= NUM_SLOTS; s++) begin
            if (slot_idx == SIDX_W'(s)) cur_word = words[s];
        end
    end

    assign bit_o = cur_word[bit_idx];

endmodule

// File: rtl/acl_out_framer.sv
module acl_out_framer #(
    parameter int TAG_W     = acl_pkg::ACL_TAG_W,
    parameter int SLOT_W    = acl_pkg::ACL_SLOT_W,
    parameter int NUM_SLOTS = acl_pkg::ACL_NSLOTS,
    parameter int ADDR_W    = acl_pkg::ACL_ADDR_W,
    parameter int DATA_W    = acl_pkg::ACL_DATA_W,
    parameter int KEEP_W    = acl_pkg::ACL_KEEP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_rd,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              pcm_l_valid,
    output logic              pcm_l_ready,
    input  logic [SLOT_W-1:0] pcm_l_data,
    input  logic              pcm_r_valid,
    output logic              pcm_r_ready,
    input  logic [SLOT_W-1:0] pcm_r_data,
    output logic              sync_o,
    output logic              sdata_o
);

    localparam int SIDX_W = $clog2(NUM_SLOTS + 1);
    localparam int BIT_W  = $clog2(SLOT_W);

    typedef struct packed {
        logic sync;
        logic sdata;
    } line_t;

    logic              frame_end;
    logic [SIDX_W-1:0] slot_idx;
    logic [BIT_W-1:0]  bit_idx;
    logic              mux_bit;
    acl_pkg::shadow_t  shadow;
    line_t             line_d, line_q;

    acl_frame_timer #(
        .TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS)
    ) u_timer (
        .clk(clk), .rst_n(rst_n),
        .slot_idx(slot_idx), .bit_idx(bit_idx), .frame_end(frame_end)
    );

    acl_field_latch #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOT_W(SLOT_W)
    ) u_latch (
        .clk(clk), .rst_n(rst_n), .load(frame_end),
        .cmd_valid(cmd_valid), .cmd_rd(cmd_rd),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .l_valid(pcm_l_valid), .l_data(pcm_l_data),
        .r_valid(pcm_r_valid), .r_data(pcm_r_data),
        .shadow(shadow)
    );

    acl_slot_mux #(
        .TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEEP_W(KEEP_W)
    ) u_mux (
        .shadow(shadow), .slot_idx(slot_idx), .bit_idx(bit_idx),
        .bit_o(mux_bit)
    );

    always_comb begin
        line_d.sync  = (slot_idx == '0);
        line_d.sdata = mux_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '0;
        end else begin
            line_q <= line_d;
        end
    end

    assign sync_o      = line_q.sync;
    assign sdata_o     = line_q.sdata;
    assign cmd_ready   = frame_end;
    assign pcm_l_ready = frame_end;
    assign pcm_r_ready = frame_end;

endmodule

// File: rtl/acl_out_framer_chk.sv
module acl_out_framer_chk #(
    parameter int TAG_W     = acl_pkg::ACL_TAG_W,
    parameter int SLOT_W    = acl_pkg::ACL_SLOT_W,
    parameter int NUM_SLOTS = acl_pkg::ACL_NSLOTS,
    parameter int ADDR_W    = acl_pkg::ACL_ADDR_W,
    parameter int DATA_W    = acl_pkg::ACL_DATA_W,
    parameter int KEEP_W    = acl_pkg::ACL_KEEP_W
) (
    input logic clk,
    input logic rst_n,
    input logic cmd_ready,
    input logic pcm_l_ready,
    input logic pcm_r_ready,
    input logic sync_o,
    input logic sdata_o
);

    localparam int FRAME_LEN = TAG_W + NUM_SLOTS * SLOT_W;
    localparam int POS_W     = $clog2(FRAME_LEN);
    localparam int S1        = TAG_W;
    localparam int S2        = S1 + SLOT_W;
    localparam int S3        = S2 + SLOT_W;
    localparam int S4        = S3 + SLOT_W;
    localparam int S5        = S4 + SLOT_W;

    // Position of the bit currently on the line; last position before the first frame.
    logic [POS_W-1:0] pos_q;
    int               p;
    logic             pad_pos;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= POS_W'(FRAME_LEN - 1);
        else if (pos_q == POS_W'(FRAME_LEN - 1)) pos_q <= '0;
        else pos_q <= pos_q + 1'b1;
    end

    always_comb begin
        p = int'(pos_q);
        pad_pos = ((p >= 5) && (p < S1))
               || ((p >= S1 + 1 + ADDR_W) && (p < S2))
               || ((p >= S2 + DATA_W) && (p < S3))
               || ((p >= S3 + KEEP_W) && (p < S4))
               || ((p >= S4 + KEEP_W) && (p < S5));
    end

    // R1
    sync_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_o == (int'(pos_q) < TAG_W));

    // R2
    ready_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready == (int'(pos_q) == FRAME_LEN - 2));

    // R2
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |=> !cmd_ready);

    // R2
    ready_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pcm_l_ready == cmd_ready) && (pcm_r_ready == cmd_ready));

    // R2
    ready_then_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> ##2 $rose(sync_o));

    // R7
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(pos_q) >= S5) |-> !sdata_o);

    // R3 R4 R5 R6
    padding_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pad_pos |-> !sdata_o);

endmodule

bind acl_out_framer acl_out_framer_chk #(
    .TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEEP_W(KEEP_W)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .cmd_ready(cmd_ready), .pcm_l_ready(pcm_l_ready), .pcm_r_ready(pcm_r_ready),
    .sync_o(sync_o), .sdata_o(sdata_o)
);

// File: tb/acl_out_framer_test.sv
module acl_out_framer_test;

    localparam int CLK_PERIOD = 10;
    localparam int FLEN       = 256;
    localparam int NFRAMES    = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_rd = 1'b0;
    logic [6:0]  cmd_addr = '0;
    logic [15:0] cmd_wdata = '0;
    logic        pcm_l_valid = 1'b0, pcm_r_valid = 1'b0;
    logic [19:0] pcm_l_data = '0, pcm_r_data = '0;
    logic        cmd_ready, pcm_l_ready, pcm_r_ready, sync_o, sdata_o;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acl_out_framer uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_rd(cmd_rd),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .pcm_l_valid(pcm_l_valid), .pcm_l_ready(pcm_l_ready), .pcm_l_data(pcm_l_data),
        .pcm_r_valid(pcm_r_valid), .pcm_r_ready(pcm_r_ready), .pcm_r_data(pcm_r_data),
        .sync_o(sync_o), .sdata_o(sdata_o)
    );

    // Frame vector: bit FLEN-1 goes out first.
    function automatic logic [FLEN-1:0] build_frame(
        input logic cv, input logic rd, input logic [6:0] a, input logic [15:0] wd,
        input logic lv, input logic [19:0] l, input logic rv, input logic [19:0] r);
        logic [FLEN-1:0] f;
        logic [15:0] tag;
        logic [19:0] s1, s2, s3, s4;
        tag = '0;
        tag[14] = cv;
        tag[13] = cv & ~rd;
        tag[12] = lv;
        tag[11] = rv;
        tag[15] = cv | lv | rv;
        s1 = cv ? {rd, a, 12'h000} : 20'h0;
        s2 = (cv && !rd) ? {wd, 4'h0} : 20'h0;
        s3 = lv ? {l[19:2], 2'b00} : 20'h0;
        s4 = rv ? {r[19:2], 2'b00} : 20'h0;
        f = '0;
        f[FLEN-1 -: 16]  = tag;
        f[FLEN-17 -: 20] = s1;
        f[FLEN-37 -: 20] = s2;
        f[FLEN-57 -: 20] = s3;
        f[FLEN-77 -: 20] = s4;
        return f;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [159:0] act, input logic [159:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic set_stim(input int f);
        case (f)
            0: begin
                cmd_valid = 1; cmd_rd = 0; cmd_addr = 7'h7F; cmd_wdata = 16'hFFFF;
                pcm_l_valid = 1; pcm_l_data = 20'hFFFFF;
                pcm_r_valid = 1; pcm_r_data = 20'hFFFFF;
            end
            1: begin
                cmd_valid = 1; cmd_rd = 1; cmd_addr = 7'h2A; cmd_wdata = 16'hBEEF;
                pcm_l_valid = 1; pcm_l_data = 20'h12345;
                pcm_r_valid = 0; pcm_r_data = 20'hABCDE;
            end
            2: begin
                cmd_valid = 0; cmd_rd = 0; cmd_addr = 7'h55; cmd_wdata = 16'h1234;
                pcm_l_valid = 0; pcm_l_data = 20'hFFFFF;
                pcm_r_valid = 0; pcm_r_data = 20'hFFFFF;
            end
            3: begin
                cmd_valid = 0;
                pcm_l_valid = 0;
                pcm_r_valid = 1; pcm_r_data = 20'h80003;
            end
            4: begin
                cmd_valid = 1; cmd_rd = 1; cmd_addr = 7'h00; cmd_wdata = 16'hFFFF;
                pcm_l_valid = 1; pcm_l_data = 20'h00001;
                pcm_r_valid = 1; pcm_r_data = 20'h00002;
            end
            default: begin
                cmd_valid   = 1'($urandom_range(0, 1));
                cmd_rd      = 1'($urandom_range(0, 1));
                cmd_addr    = 7'($urandom);
                cmd_wdata   = 16'($urandom);
                pcm_l_valid = 1'($urandom_range(0, 1));
                pcm_l_data  = 20'($urandom);
                pcm_r_valid = 1'($urandom_range(0, 1));
                pcm_r_data  = 20'($urandom);
            end
        endcase
    endtask

    initial begin
        int wd_cycles = 0;
        forever begin
            @(posedge clk);
            wd_cycles++;
            if (wd_cycles > 150000) begin
                n_run++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    initial begin
        logic [FLEN-1:0] cur, nxt, got_d, got_s, exp_sync;
        int bpos;
        int rdy_err;
        void'($urandom(32'h5EED_1234));
        exp_sync = '0;
        exp_sync[FLEN-1 -: 16] = 16'hFFFF;
        cur = '0; nxt = '0; got_d = '0; got_s = '0;
        bpos = FLEN - 1;
        rdy_err = 0;

        repeat (3) @(negedge clk);
        // R9: outputs quiet under reset
        check("R9", "reset outputs", {156'h0, sync_o, sdata_o, cmd_ready, pcm_l_ready | pcm_r_ready}, 160'h0);
        rst_n = 1'b1;

        for (int f = 0; f < NFRAMES; f++) begin
            for (int c = 0; c < FLEN; c++) begin
                @(negedge clk);
                bpos = (bpos + 1) % FLEN;
                if (bpos == 0) cur = nxt;
                got_d[FLEN-1-bpos] = sdata_o;
                got_s[FLEN-1-bpos] = sync_o;
                if ((cmd_ready !== (bpos == FLEN-2)) || (pcm_l_ready !== cmd_ready)
                    || (pcm_r_ready !== cmd_ready)) rdy_err++;
                if (bpos == 100) set_stim(f);
                if (bpos == FLEN - 2 && cmd_ready)
                    nxt = build_frame(cmd_valid, cmd_rd, cmd_addr, cmd_wdata,
                                      pcm_l_valid, pcm_l_data, pcm_r_valid, pcm_r_data);
                if (bpos == FLEN - 1) begin
                    // R1 frame marker window
                    check("R1", "sync pattern", 160'(got_s), 160'(exp_sync));
                    // R2 single ready pulse at bit 254
                    check("R2", "ready errors", 160'(rdy_err), 160'h0);
                    rdy_err = 0;
                    if (f == 0) begin
                        // R9 first frame empty
                        check("R9", "first frame", 160'(got_d[FLEN-1 -: 96]), 160'h0);
                    end
                    // R3 R8 tag
                    check("R3 R8", "tag", 160'(got_d[FLEN-1 -: 16]), 160'(cur[FLEN-1 -: 16]));
                    // R4 R8 slot 1
                    check("R4 R8", "slot1", 160'(got_d[FLEN-17 -: 20]), 160'(cur[FLEN-17 -: 20]));
                    // R5 slot 2
                    check("R5", "slot2", 160'(got_d[FLEN-37 -: 20]), 160'(cur[FLEN-37 -: 20]));
                    // R6 slots 3 and 4
                    check("R6", "slot3/4", 160'(got_d[FLEN-57 -: 40]), 160'(cur[FLEN-57 -: 40]));
                    // R7 reserved slots
                    check("R7", "slots5-12", got_d[159:0], 160'h0);
                end
            end
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule